// File: doc/BRIEF.md
# Multiprocessor Address Filter for a 9-bit Serial Receiver

This block sits next to the receive shifter of a 9-bit asynchronous serial port that is used on a shared multi-drop line. Each received frame reaches the block as a data byte, a ninth bit and a stop-bit status, together with a one-cycle valid strobe. While multiprocessor operation is on, a frame whose ninth bit is 1 carries an address. The block compares that address against the node's own address under a mask, and also against a broadcast pattern derived from the same two bytes. A hit selects the node. The address frame and the data frames that follow it are then delivered with a receive flag, until a non-matching address frame deselects the node again.

The node address and the mask are plain inputs, held by whatever register owns them. A mask bit of 0 makes that address bit don't-care, so one node answers to a whole family of addresses. The broadcast pattern is the address ORed with the mask. Every bit that is 1 in that pattern must be 1 in the received byte, and every other bit is ignored. A framing-error select input decides what the status output shows. When it is set, the output shows a sticky framing-error flag, raised by any frame received without its stop bit. When it is clear, the output shows the stop bit of the last frame. The shifter and the baud generator are outside the block.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, rx_flag_o, selected_o and fe_flag_o are 0 and status_o is 1. rx_flag_o is never 1 in the cycle after a cycle without rx_valid_i.
- R2: With mp_en_i=1, a frame with rx_bit8_i=1 is a given-address hit when rx_data_i equals node_addr_i in every bit where node_mask_i is 1. On a hit, rx_flag_o pulses and selected_o becomes 1 one cycle after the frame.
- R3: With node_mask_i=00h, every address frame is a given-address hit.
- R4: An address frame is a broadcast hit when every bit that is 1 in (node_addr_i OR node_mask_i) is also 1 in rx_data_i. A broadcast hit selects the node just as R2 does, so FFh always selects the node.
- R5: With mp_en_i=1, an address frame that is neither a given-address hit nor a broadcast hit gives no rx_flag_o pulse and clears selected_o one cycle later.
- R6: With mp_en_i=1, a frame with rx_bit8_i=0 pulses rx_flag_o only while selected_o is 1, and does not change selected_o.
- R7: With mp_en_i=0, every frame pulses rx_flag_o and leaves selected_o unchanged.
- R8: With fe_sel_i=1, a frame with rx_stop_i=0 sets fe_flag_o one cycle later, and status_o then shows fe_flag_o.
- R9: fe_flag_o stays 1 until a cycle with fe_clr_i=1. A framing error in the same cycle as fe_clr_i keeps the flag at 1.
- R10: With fe_sel_i=0, a missing stop bit does not set fe_flag_o. In that mode status_o shows the rx_stop_i value of the last frame received.
- R11: When rx_flag_o pulses, rx_byte_o holds the delivered byte and rx_is_addr_o holds its ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_en_i | input | 1 | Multiprocessor address filtering on |
| fe_sel_i | input | 1 | Status output shows the framing-error flag |
| fe_clr_i | input | 1 | Clears the framing-error flag |
| node_addr_i | input | DATA_W | Node address |
| node_mask_i | input | DATA_W | Address mask, 0 = don't-care |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_data_i | input | DATA_W | Received byte |
| rx_bit8_i | input | 1 | Received ninth bit |
| rx_stop_i | input | 1 | Stop bit seen (1) or missing (0) |
| rx_flag_o | output | 1 | Frame delivered, one-cycle pulse |
| rx_byte_o | output | DATA_W | Delivered byte |
| rx_is_addr_o | output | 1 | Delivered frame was an address frame |
| selected_o | output | 1 | Node currently selected |
| fe_flag_o | output | 1 | Sticky framing-error flag |
| status_o | output | 1 | Framing-error flag or last stop bit, chosen by fe_sel_i |

## Verification
Every result of the block is registered once. rx_flag_o, rx_byte_o, rx_is_addr_o, selected_o, fe_flag_o and the stop-bit copy behind status_o all change on the first rising edge that samples rx_valid_i. The bench drives each frame on a falling edge and holds it for one cycle. It withdraws the strobe on the next falling edge and compares the outputs at that same instant, half a cycle after the update. The vector table runs as one ordered sequence, because the expected value of selected_o depends on the vectors before it. The framing-error and clear cases follow the same one-cycle rule.

// File: rtl/mp_filt_pkg.sv
package mp_filt_pkg;
  typedef enum logic [1:0] {
    FR_NONE = 2'd0,
    FR_ADDR = 2'd1,
    FR_DATA = 2'd2,
    FR_RAW  = 2'd3
  } fr_kind_e;
endpackage

// File: rtl/mp_addr_match.sv
module mp_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] own_mask,
  output logic              given_hit,
  output logic              bcast_hit
);
  logic [DATA_W-1:0] given_ok;
  logic [DATA_W-1:0] bcast_ok;

  // Per-bit compare: a masked-off bit always agrees; a broadcast bit
  // is only demanded where address OR mask is one.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign given_ok[b] = ~own_mask[b] | ~(rx_byte[b] ^ own_addr[b]);
    assign bcast_ok[b] = ~(own_addr[b] | own_mask[b]) | rx_byte[b];
  end

  assign given_hit = &given_ok;
  assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/mp_sel_ctrl.sv
module mp_sel_ctrl
  import mp_filt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_bit8,
  input  logic              addr_hit,
  output logic              flag_q,
  output logic [DATA_W-1:0] byte_q,
  output logic              is_addr_q,
  output logic              sel_q
);
  fr_kind_e          kind;
  logic              flag_d;
  logic              sel_d;
  logic              take_byte;

  always_comb begin
    if (!rx_valid)    kind = FR_NONE;
    else if (!mp_en)  kind = FR_RAW;
    else if (rx_bit8) kind = FR_ADDR;
    else              kind = FR_DATA;
  end

  always_comb begin
    flag_d = 1'b0;
    sel_d  = sel_q;
    unique case (kind)
      FR_NONE: ;
      FR_RAW:  flag_d = 1'b1;
      FR_ADDR: begin
        flag_d = addr_hit;
        sel_d  = addr_hit;
      end
      FR_DATA: flag_d = sel_q;
    endcase
  end

  assign take_byte = flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q    <= '0;
      is_addr_q <= 1'b0;
    end else if (take_byte) begin
      byte_q    <= rx_byte;
      is_addr_q <= rx_bit8;
    end
  end
endmodule

// File: rtl/mp_frame_err.sv
module mp_frame_err (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_stop,
  input  logic fe_sel,
  input  logic fe_clr,
  output logic fe_q,
  output logic stop_q
);
  logic fe_d;
  logic stop_d;
  logic fe_set;

  assign fe_set = rx_valid & fe_sel & ~rx_stop;

  always_comb begin
    fe_d = fe_q;
    if (fe_clr) fe_d = 1'b0;
    if (fe_set) fe_d = 1'b1;
    stop_d = rx_valid ? rx_stop : stop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q   <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      fe_q   <= fe_d;
      stop_q <= stop_d;
    end
  end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_en_i,
  input  logic              fe_sel_i,
  input  logic              fe_clr_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic [DATA_W-1:0] node_mask_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_bit8_i,
  input  logic              rx_stop_i,
  output logic              rx_flag_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_is_addr_o,
  output logic              selected_o,
  output logic              fe_flag_o,
  output logic              status_o
);
  localparam int SYNC_MSB = SYNC_STG - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_n_int;
  logic              given_hit;
  logic              bcast_hit;
  logic              stop_last;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_MSB];

  mp_addr_match #(.DATA_W(DATA_W)) u_match (
    .rx_byte   (rx_data_i),
    .own_addr  (node_addr_i),
    .own_mask  (node_mask_i),
    .given_hit (given_hit),
    .bcast_hit (bcast_hit)
  );

  mp_sel_ctrl #(.DATA_W(DATA_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mp_en     (mp_en_i),
    .rx_valid  (rx_valid_i),
    .rx_byte   (rx_data_i),
    .rx_bit8   (rx_bit8_i),
    .addr_hit  (given_hit | bcast_hit),
    .flag_q    (rx_flag_o),
    .byte_q    (rx_byte_o),
    .is_addr_q (rx_is_addr_o),
    .sel_q     (selected_o)
  );

  mp_frame_err u_fe (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rx_valid (rx_valid_i),
    .rx_stop  (rx_stop_i),
    .fe_sel   (fe_sel_i),
    .fe_clr   (fe_clr_i),
    .fe_q     (fe_flag_o),
    .stop_q   (stop_last)
  );

  assign status_o = fe_sel_i ? fe_flag_o : stop_last;
endmodule

// File: rtl/mp_addr_filter_chk.sv
module mp_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_en_i,
  input logic              fe_sel_i,
  input logic              fe_clr_i,
  input logic [DATA_W-1:0] node_addr_i,
  input logic [DATA_W-1:0] node_mask_i,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_bit8_i,
  input logic              rx_stop_i,
  input logic              rx_flag_o,
  input logic [DATA_W-1:0] rx_byte_o,
  input logic              rx_is_addr_o,
  input logic              selected_o,
  input logic              fe_flag_o,
  input logic              status_o
);
  logic [DATA_W-1:0] bpat;
  logic              miss;
  assign bpat = node_addr_i | node_mask_i;
  assign miss = (((rx_data_i ^ node_addr_i) & node_mask_i) != '0) &&
                ((rx_data_i & bpat) != bpat);

  // R1
  flag_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> !rx_flag_o);

  // R4
  bcast_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && mp_en_i && rx_bit8_i && (&rx_data_i)) |=> (rx_flag_o && selected_o));

  // R5
  miss_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && mp_en_i && rx_bit8_i && miss) |=> (!rx_flag_o && !selected_o));

  // R6
  data_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && mp_en_i && !rx_bit8_i && !selected_o) |=> !rx_flag_o);

  // R7
  raw_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !mp_en_i) |=> (rx_flag_o && selected_o == $past(selected_o)));

  // R8
  fe_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && fe_sel_i && !rx_stop_i) |=> fe_flag_o);

  // R9
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_flag_o && !fe_clr_i) |=> fe_flag_o);

  // R10
  stop_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !fe_sel_i && !rx_stop_i) |=> (fe_sel_i || !status_o));

  // R11
  raw_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !mp_en_i) |=> (rx_byte_o == $past(rx_data_i) &&
                                  rx_is_addr_o == $past(rx_bit8_i)));
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mp_en_i      (mp_en_i),
  .fe_sel_i     (fe_sel_i),
  .fe_clr_i     (fe_clr_i),
  .node_addr_i  (node_addr_i),
  .node_mask_i  (node_mask_i),
  .rx_valid_i   (rx_valid_i),
  .rx_data_i    (rx_data_i),
  .rx_bit8_i    (rx_bit8_i),
  .rx_stop_i    (rx_stop_i),
  .rx_flag_o    (rx_flag_o),
  .rx_byte_o    (rx_byte_o),
  .rx_is_addr_o (rx_is_addr_o),
  .selected_o   (selected_o),
  .fe_flag_o    (fe_flag_o),
  .status_o     (status_o)
);

// File: tb/mp_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mp_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mp_en = 1'b0, fe_sel = 1'b0, fe_clr = 1'b0;
  logic [7:0] addr = 8'h00, mask = 8'h00, rdata = 8'h00;
  logic       rvalid = 1'b0, rb8 = 1'b0, rstop = 1'b1;
  logic       flag, is_addr, sel, fe, status;
  logic [7:0] rbyte;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  mp_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .mp_en_i(mp_en), .fe_sel_i(fe_sel),
    .fe_clr_i(fe_clr), .node_addr_i(addr), .node_mask_i(mask),
    .rx_valid_i(rvalid), .rx_data_i(rdata), .rx_bit8_i(rb8),
    .rx_stop_i(rstop), .rx_flag_o(flag), .rx_byte_o(rbyte),
    .rx_is_addr_o(is_addr), .selected_o(sel), .fe_flag_o(fe),
    .status_o(status)
  );

  // {req, mp_en, bit8, data, addr, mask, exp_flag, exp_sel}
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    {4'd6, 1'b1,1'b0, 8'h11, 8'h35,8'hF0, 1'b0,1'b0}, // R6 not selected
    {4'd2, 1'b1,1'b1, 8'h3C, 8'h35,8'hF0, 1'b1,1'b1}, // R2 masked hit
    {4'd6, 1'b1,1'b0, 8'h77, 8'h35,8'hF0, 1'b1,1'b1}, // R6 selected data
    {4'd5, 1'b1,1'b1, 8'h45, 8'h35,8'hF0, 1'b0,1'b0}, // R5 miss
    {4'd6, 1'b1,1'b0, 8'h99, 8'h35,8'hF0, 1'b0,1'b0}, // R6 dropped
    {4'd4, 1'b1,1'b1, 8'hF7, 8'h35,8'hF0, 1'b1,1'b1}, // R4 broadcast
    {4'd5, 1'b1,1'b1, 8'hF4, 8'h35,8'hF0, 1'b0,1'b0}, // R5 near-broadcast
    {4'd4, 1'b1,1'b1, 8'hFF, 8'h35,8'hF0, 1'b1,1'b1}, // R4 FFh
    {4'd7, 1'b0,1'b0, 8'h12, 8'h35,8'hF0, 1'b1,1'b1}, // R7 raw keeps sel
    {4'd5, 1'b1,1'b1, 8'h00, 8'h35,8'hF0, 1'b0,1'b0}, // R5 miss
    {4'd7, 1'b0,1'b1, 8'h00, 8'h35,8'hF0, 1'b1,1'b0}, // R7 raw addr frame
    {4'd6, 1'b1,1'b0, 8'h5A, 8'h35,8'hF0, 1'b0,1'b0}, // R6 dropped
    {4'd3, 1'b1,1'b1, 8'h00, 8'h35,8'h00, 1'b1,1'b1}, // R3 mask zero
    {4'd3, 1'b1,1'b1, 8'h7E, 8'h80,8'h00, 1'b1,1'b1}, // R3 mask zero
    {4'd2, 1'b1,1'b1, 8'h0F, 8'h0F,8'hFF, 1'b1,1'b1}, // R2 exact
    {4'd5, 1'b1,1'b1, 8'h0E, 8'h0F,8'hFF, 1'b0,1'b0}, // R5 one bit off
    {4'd4, 1'b1,1'b1, 8'hFF, 8'h0F,8'hFF, 1'b1,1'b1}  // R4 FFh full mask
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one frame for one cycle; outputs are compared half a cycle
  // after the edge that registers them.
  task automatic frame(input logic m, input logic b8, input logic st,
                       input logic [7:0] d);
    @(negedge clk);
    mp_en = m; rb8 = b8; rstop = st; rdata = d; rvalid = 1'b1;
    @(negedge clk);
    rvalid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "flag", {7'd0, flag}, 8'd0);
    chk("R1", "selected", {7'd0, sel}, 8'd0);
    chk("R1", "fe_flag", {7'd0, fe}, 8'd0);
    chk("R1", "status", {7'd0, status}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[31:28], i);
      addr = v[17:10]; mask = v[9:2];
      frame(v[27], v[26], 1'b1, v[25:18]);
      chk(rq, "flag", {7'd0, flag}, {7'd0, v[1]});
      chk(rq, "selected", {7'd0, sel}, {7'd0, v[0]});
      if (v[1]) begin
        // R11 delivered byte and ninth bit
        chk("R11", "byte", rbyte, v[25:18]);
        chk("R11", "is_addr", {7'd0, is_addr}, {7'd0, v[26]});
      end
      @(negedge clk);
      // R1 no pulse without a frame
      chk("R1", "idle flag", {7'd0, flag}, 8'd0);
    end

    // R10 stop bit shown, no framing flag when select is clear
    fe_sel = 1'b0;
    frame(1'b0, 1'b0, 1'b0, 8'h21);
    chk("R10", "fe_flag", {7'd0, fe}, 8'd0);
    chk("R10", "status", {7'd0, status}, 8'd0);
    frame(1'b0, 1'b0, 1'b1, 8'h22);
    chk("R10", "status", {7'd0, status}, 8'd1);

    // R8 framing error raised
    fe_sel = 1'b1;
    frame(1'b0, 1'b0, 1'b0, 8'h23);
    chk("R8", "fe_flag", {7'd0, fe}, 8'd1);
    chk("R8", "status", {7'd0, status}, 8'd1);
    // R9 sticky across good frame
    frame(1'b0, 1'b0, 1'b1, 8'h24);
    chk("R9", "sticky", {7'd0, fe}, 8'd1);
    // R9 clear
    @(negedge clk); fe_clr = 1'b1;
    @(negedge clk); fe_clr = 1'b0;
    chk("R9", "cleared", {7'd0, fe}, 8'd0);
    chk("R8", "status clear", {7'd0, status}, 8'd0);
    // R9 error wins over clear
    @(negedge clk);
    mp_en = 1'b0; rstop = 1'b0; rvalid = 1'b1; fe_clr = 1'b1;
    @(negedge clk);
    rvalid = 1'b0; fe_clr = 1'b0;
    chk("R9", "set over clear", {7'd0, fe}, 8'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule